// File: doc/BRIEF.md
# Partial Reconfiguration Engine Register Controller

This block sits between a 64-bit register bus and the loader of a partial reconfiguration engine. Software uses a small set of 64-bit registers to drive it. It resets the engine and waits for the acknowledge, picks a target region and raises a start request, then pushes 32-bit configuration words. Each push spends one credit of a small internal FIFO. Software then signals that the push is complete. The engine drains the FIFO through a valid/ready port, drops the start request by itself, and returns to idle.

Faults are collected as sticky bits in an error register, and software clears them by writing 1. Some faults come from the engine logic that lies outside this block, and they arrive as one-cycle strobes. The block raises two faults of its own: a data write at the wrong time, and a data write into a full FIFO. Reads are combinational from the read address. The bus address is a byte address, and bits 2:0 are ignored.

Top module: `pr_csr_ctrl`

## Requirements
- R1: After reset the following values hold. Control (byte 0x08) reads 0. Status (0x10) reads the credit equal to the FIFO depth in bits 8:0, with every other bit 0. Error (0x20) reads 0. Header (0x00) reads the FEATURE_HDR parameter.
- R2: Reset handshake, part one. Writing control with bit 0 set enters the reset state. While in reset, the FIFO is flushed (credit returns to the depth), the acknowledge bit 4 reads 1 and host status reads 2.
- R2 (continued): Writing bit 0 back to 0 clears the acknowledge. Host status then returns to 0 within INIT_CYCLES+2 cycles.
- R3: Start request. In idle, a control write with bit 12 set enters loading. Control bit 12 then reads 1. Status bits 27:24 (host status) read 1, and bits 22:20 (controller status) read 1. Control bits 9:8 (region), bit 14 (image kind) and bits 63:32 (config data) read back as written.
- R4: While loading, a write to the data register (0x18) pushes bits 31:0 into the FIFO, and bits 63:32 are ignored. The credit drops by one in the cycle after each push and rises by one after each pop. The drain port delivers the words in the order they were written.
- R5: A data write while the FIFO is full sets error bit 4, and the word is dropped.
- R6: A data write while the start request is clear sets error bit 3 and changes neither the FIFO nor the credit.
- R7: A control write with bit 13 set while loading makes the following happen in order. Bit 13 reads 1 and the FIFO drains (controller status 2). Then, after FINISH_CYCLES, bits 12 and 13 both clear, and host and controller status return to 0.
- R8: The error bits are mapped as follows. Bit 0 is operation, bit 1 is CRC, bit 2 is incompatible image, bit 6 is secure load. Each of these is set by the matching hw_err_i strobe bit. Bit 5 is reserved and never sets. Bits 63:7 read 0. Writing 1 clears only the written bits. Status bit 16 is the OR of all the error bits.
- R9: Control bits outside the fields named above read 0. The interface identifier reads IFC_ID_LO at 0xA8 and IFC_ID_HI at 0xB0, and writes to those addresses have no effect.
- R10: The drain port never shows valid while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 64 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 64 | Read data, combinational from rd_addr |
| hw_err_i | input | 7 | Engine fault strobes, one bit per error position |
| drain_valid | output | 1 | A configuration word is offered |
| drain_data | output | 32 | Offered configuration word |
| drain_ready | input | 1 | Consumer takes the word this cycle |
| region_o | output | 2 | Selected region |
| kind_o | output | 1 | Selected image kind |

## Verification
The bench uses a four-deep FIFO. It sweeps the fill level from empty to full and checks the credit arithmetically after every push. A fifth push then tells a correct overflow drop apart from a silent wrap. The drained sequence is compared word by word, which separates in-order delivery from pointer slips and shows that the dropped word never appears.

Data writes are tried in idle and during loading, and a reset is applied in the middle of a load. These cases distinguish protocol rejection from acceptance, and a real flush from a mere state change. For the error map, the bench uses an all-ones strobe, a partial write-1 clear and a write to the high bits only. These expose a reserved bit that sets, an over-wide clear, and phantom high bits.

// File: rtl/pr_csr_pkg.sv
package pr_csr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOAD   = 3'd1,
      ST_DRAIN  = 3'd2,
      ST_FINISH = 3'd3,
      ST_RESET  = 3'd4,
      ST_INIT   = 3'd5
   } pr_state_e;

   // register word indices (byte address >> 3)
   localparam int unsigned WI_HDR   = 0;
   localparam int unsigned WI_CTRL  = 1;
   localparam int unsigned WI_STAT  = 2;
   localparam int unsigned WI_DATA  = 3;
   localparam int unsigned WI_ERR   = 4;
   localparam int unsigned WI_IDLO  = 21;
   localparam int unsigned WI_IDHI  = 22;

   // error bit positions
   localparam int unsigned ERR_W       = 7;
   localparam int unsigned EB_PROTO    = 3;
   localparam int unsigned EB_OVF      = 4;
   localparam logic [ERR_W-1:0] ERR_RSVD_MASK = 7'b010_0000;

   // host status codes
   localparam logic [3:0] HS_IDLE = 4'd0;
   localparam logic [3:0] HS_BUSY = 4'd1;
   localparam logic [3:0] HS_INIT = 4'd2;

   localparam int unsigned CRED_W = 9;

endpackage

// File: rtl/pr_word_fifo.sv
module pr_word_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] count
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   initial assert (DEPTH >= 2) else $error("pr_word_fifo: DEPTH must be at least 2");

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= din;
   end

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0)); // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R4

endmodule

// File: rtl/pr_seq.sv
module pr_seq
   import pr_csr_pkg::*;
#(
   parameter int INIT_CYCLES   = 4,
   parameter int FINISH_CYCLES = 3,
   localparam int CMAX = (INIT_CYCLES > FINISH_CYCLES) ? INIT_CYCLES : FINISH_CYCLES,
   localparam int CW   = $clog2(CMAX + 1)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rst_req_i,
   input  logic      start_i,
   input  logic      push_i,
   input  logic      fifo_empty_i,
   output pr_state_e state_o
);

   pr_state_e     state;
   logic [CW-1:0] cnt;

   initial assert (INIT_CYCLES >= 1 && FINISH_CYCLES >= 1)
      else $error("pr_seq: cycle counts must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else if (rst_req_i) begin
         state <= ST_RESET;
         cnt   <= '0;
      end else begin
         case (state)
            ST_RESET: begin
               state <= ST_INIT;
               cnt   <= CW'(INIT_CYCLES - 1);
            end
            ST_INIT: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            ST_IDLE:  if (start_i) state <= ST_LOAD;
            ST_LOAD:  if (push_i)  state <= ST_DRAIN;
            ST_DRAIN: begin
               if (fifo_empty_i) begin
                  state <= ST_FINISH;
                  cnt   <= CW'(FINISH_CYCLES - 1);
               end
            end
            ST_FINISH: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state;

   AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_i |=> (state == ST_RESET)); // R2
   AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN && fifo_empty_i && !rst_req_i) |=> (state == ST_FINISH)); // R7

endmodule

// File: rtl/pr_err_bank.sv
module pr_err_bank #(
   parameter int          WIDTH     = 7,
   parameter logic [WIDTH-1:0] RSVD_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] err_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (RSVD_MASK[i]) begin : g_rsvd
         assign err_o[i] = 1'b0;
      end else begin : g_live
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (set_i[i]) bit_q <= 1'b1;
            else if (clr_i[i]) bit_q <= 1'b0;
         end
         assign err_o[i] = bit_q;
      end
   end

endmodule

// File: rtl/pr_csr_ctrl.sv
module pr_csr_ctrl
   import pr_csr_pkg::*;
#(
   parameter int          ADDR_W        = 8,
   parameter int          FIFO_DEPTH    = 16,
   parameter int          INIT_CYCLES   = 4,
   parameter int          FINISH_CYCLES = 3,
   parameter logic [63:0] FEATURE_HDR   = 64'h3000_0000_1000_0005,
   parameter logic [63:0] IFC_ID_LO     = 64'h0123_4567_89AB_CDEF,
   parameter logic [63:0] IFC_ID_HI     = 64'hFEDC_BA98_7654_3210
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [63:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [63:0]       rd_data,
   input  logic [ERR_W-1:0]  hw_err_i,
   output logic              drain_valid,
   output logic [31:0]       drain_data,
   input  logic              drain_ready,
   output logic [1:0]        region_o,
   output logic              kind_o
);

   localparam int WIDX_W = ADDR_W - 3;
   localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

   initial assert (ADDR_W >= 8) else $error("pr_csr_ctrl: ADDR_W too small for map");
   initial assert (FIFO_DEPTH >= 2 && FIFO_DEPTH <= 511)
      else $error("pr_csr_ctrl: FIFO_DEPTH must lie in 2..511");

   // ---------------- decode ----------------
   logic [WIDX_W-1:0] w_idx, r_idx;
   logic ctrl_wr, data_wr, err_wr;

   assign w_idx   = wr_addr[ADDR_W-1:3];
   assign r_idx   = rd_addr[ADDR_W-1:3];
   assign ctrl_wr = wr_en && (w_idx == WIDX_W'(WI_CTRL));
   assign data_wr = wr_en && (w_idx == WIDX_W'(WI_DATA));
   assign err_wr  = wr_en && (w_idx == WIDX_W'(WI_ERR));

   // ---------------- control fields ----------------
   logic        rst_req_q, kind_q;
   logic [1:0]  region_q;
   logic [31:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req_q <= 1'b0;
         region_q  <= '0;
         kind_q    <= 1'b0;
         cfg_q     <= '0;
      end else if (ctrl_wr) begin
         rst_req_q <= wr_data[0];
         region_q  <= wr_data[9:8];
         kind_q    <= wr_data[14];
         cfg_q     <= wr_data[63:32];
      end
   end

   assign region_o = region_q;
   assign kind_o   = kind_q;

   // ---------------- sequencer ----------------
   pr_state_e state;
   logic      fifo_empty, fifo_full;
   logic [CNT_W-1:0] fifo_cnt;

   pr_seq #(
      .INIT_CYCLES  (INIT_CYCLES),
      .FINISH_CYCLES(FINISH_CYCLES)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .rst_req_i   (rst_req_q),
      .start_i     (ctrl_wr && wr_data[12] && !wr_data[0]),
      .push_i      (ctrl_wr && wr_data[13] && !wr_data[0]),
      .fifo_empty_i(fifo_empty),
      .state_o     (state)
   );

   logic loading, start_act, push_act, in_reset;
   assign loading   = (state == ST_LOAD);
   assign start_act = (state == ST_LOAD) || (state == ST_DRAIN) || (state == ST_FINISH);
   assign push_act  = (state == ST_DRAIN) || (state == ST_FINISH);
   assign in_reset  = (state == ST_RESET) || (state == ST_INIT);

   // ---------------- word FIFO ----------------
   logic push_ok, ovf_hit, proto_hit, pop;
   assign push_ok   = data_wr && loading;
   assign ovf_hit   = push_ok && fifo_full;
   assign proto_hit = data_wr && !loading;
   assign drain_valid = !fifo_empty && (loading || state == ST_DRAIN);
   assign pop       = drain_valid && drain_ready;

   pr_word_fifo #(
      .DEPTH(FIFO_DEPTH),
      .WIDTH(32)
   ) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .flush(rst_req_q),
      .push (push_ok),
      .din  (wr_data[31:0]),
      .pop  (pop),
      .dout (drain_data),
      .empty(fifo_empty),
      .full (fifo_full),
      .count(fifo_cnt)
   );

   // ---------------- errors ----------------
   logic [ERR_W-1:0] err_set, err_clr, err_q;
   always_comb begin
      err_set = hw_err_i;
      err_set[EB_PROTO] = hw_err_i[EB_PROTO] | proto_hit;
      err_set[EB_OVF]   = hw_err_i[EB_OVF]   | ovf_hit;
   end
   assign err_clr = err_wr ? wr_data[ERR_W-1:0] : '0;

   pr_err_bank #(
      .WIDTH    (ERR_W),
      .RSVD_MASK(ERR_RSVD_MASK)
   ) u_err (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(err_set),
      .clr_i(err_clr),
      .err_o(err_q)
   );

   // ---------------- status / read mux ----------------
   logic [CRED_W-1:0] credit;
   logic [3:0]        host_st;
   logic [2:0]        ctl_st;
   logic [63:0]       ctrl_rd, stat_rd;

   assign credit = CRED_W'(FIFO_DEPTH) - CRED_W'(fifo_cnt);

   always_comb begin
      if (start_act)     host_st = HS_BUSY;
      else if (in_reset) host_st = HS_INIT;
      else               host_st = HS_IDLE;
      case (state)
         ST_LOAD:           ctl_st = 3'd1;
         ST_DRAIN:          ctl_st = 3'd2;
         ST_FINISH:         ctl_st = 3'd3;
         ST_RESET, ST_INIT: ctl_st = 3'd4;
         default:           ctl_st = 3'd0;
      endcase
   end

   assign ctrl_rd = {cfg_q, 17'b0, kind_q, push_act, start_act, 2'b0, region_q,
                     3'b0, (state == ST_RESET), 3'b0, rst_req_q};
   assign stat_rd = {36'b0, host_st, 1'b0, ctl_st, 3'b0, |err_q, 7'b0, credit};

   always_comb begin
      if      (r_idx == WIDX_W'(WI_HDR))  rd_data = FEATURE_HDR;
      else if (r_idx == WIDX_W'(WI_CTRL)) rd_data = ctrl_rd;
      else if (r_idx == WIDX_W'(WI_STAT)) rd_data = stat_rd;
      else if (r_idx == WIDX_W'(WI_ERR))  rd_data = {{(64-ERR_W){1'b0}}, err_q};
      else if (r_idx == WIDX_W'(WI_IDLO)) rd_data = IFC_ID_LO;
      else if (r_idx == WIDX_W'(WI_IDHI)) rd_data = IFC_ID_HI;
      else                                rd_data = '0;
   end

   // ---------------- assertions ----------------
   AST_PROTO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      proto_hit |=> err_q[EB_PROTO]); // R6
   AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_hit |=> err_q[EB_OVF]); // R5
   AST_CREDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && !fifo_full && !pop && !rst_req_q) |=> (credit == $past(credit) - 1'b1)); // R4
   AST_SECURE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      hw_err_i[6] |=> err_q[6]); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (host_st == HS_IDLE) |-> !drain_valid); // R10

endmodule

// File: tb/pr_csr_ctrl_tb.sv
module pr_csr_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4;
   localparam int INITC = 3;
   localparam int FINC  = 2;
   localparam logic [63:0] HDR  = 64'h1111_2222_3333_4444;
   localparam logic [63:0] IDLO = 64'hAAAA_0000_5555_0001;
   localparam logic [63:0] IDHI = 64'hBBBB_0000_6666_0002;

   logic        clk = 0, rst_n = 0, wr_en = 0, drain_ready = 0;
   logic [7:0]  wr_addr = '0, rd_addr = '0;
   logic [63:0] wr_data = '0, rd_data;
   logic [6:0]  hw_err_i = '0;
   logic        drain_valid, kind_o;
   logic [31:0] drain_data;
   logic [1:0]  region_o;

   int total = 0, bad = 0;
   logic [63:0] d;
   logic [31:0] got [DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;

   pr_csr_ctrl #(.ADDR_W(8), .FIFO_DEPTH(DEPTH), .INIT_CYCLES(INITC),
      .FINISH_CYCLES(FINC), .FEATURE_HDR(HDR), .IFC_ID_LO(IDLO), .IFC_ID_HI(IDHI)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .hw_err_i(hw_err_i),
      .drain_valid(drain_valid), .drain_data(drain_data), .drain_ready(drain_ready),
      .region_o(region_o), .kind_o(kind_o));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] v);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = v;
      @(negedge clk);
      wr_en = 0; #1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   function automatic logic [63:0] stat(input int cred, input int err, input int cst, input int hst);
      return 64'(cred) | (64'(err) << 16) | (64'(cst) << 20) | (64'(hst) << 24);
   endfunction

   task automatic do_reset_handshake(input string req);
      int n;
      wr(8'h08, 64'h1);
      n = 0;
      rd(8'h08, d);
      while (!d[4] && n < 6) begin @(negedge clk); #1; rd(8'h08, d); n++; end
      chk({req, " ack raised"}, {63'b0, d[4]}, 64'h1);
      rd(8'h10, d);
      chk({req, " host status in reset"}, {60'b0, d[27:24]}, 64'h2);
      chk({req, " credit after flush"}, {55'b0, d[8:0]}, 64'(DEPTH));
      wr(8'h08, 64'h0);
      n = 0;
      rd(8'h10, d);
      while (d[27:24] != 0 && n < 20) begin @(negedge clk); #1; rd(8'h10, d); n++; end
      chk({req, " idle within bound"}, 64'(n <= INITC + 2), 64'h1);
      rd(8'h08, d);
      chk({req, " ack cleared"}, {63'b0, d[4]}, 64'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int idx;
      repeat (3) @(negedge clk);
      rst_n = 1; #1;

      // R1 reset values
      rd(8'h08, d); chk("R1 ctrl", d, 64'h0);
      rd(8'h10, d); chk("R1 status", d, stat(DEPTH, 0, 0, 0));
      rd(8'h20, d); chk("R1 error", d, 64'h0);
      rd(8'h00, d); chk("R1 header", d, HDR);

      // R9 id read-only, reserved control bits
      wr(8'hA8, 64'hDEAD_BEEF_DEAD_BEEF);
      wr(8'hB0, 64'h0);
      rd(8'hA8, d); chk("R9 id low", d, IDLO);
      rd(8'hB0, d); chk("R9 id high", d, IDHI);
      wr(8'h08, 64'hFFFF_FFFF_FFFF_CFFE);
      rd(8'h08, d); chk("R9 ctrl reserved zero", d, 64'hFFFF_FFFF_0000_4300);
      chk("R3 kind pin", {63'b0, kind_o}, 64'h1);
      wr(8'h08, 64'h0);

      // R6 data write while idle
      drain_ready = 1;
      wr(8'h18, 64'h0000_0000_1234_5678);
      rd(8'h20, d); chk("R6 protocol bit", d, 64'h08);
      rd(8'h10, d); chk("R6 credit unchanged", d, stat(DEPTH, 1, 0, 0));
      chk("R10 no drain in idle", {63'b0, drain_valid}, 64'h0);
      drain_ready = 0;
      wr(8'h20, 64'h08);
      rd(8'h20, d); chk("R8 w1c protocol", d, 64'h0);

      // R2 reset handshake
      do_reset_handshake("R2");

      // R3 start
      wr(8'h08, 64'h0000_0000_0000_1200);
      rd(8'h08, d); chk("R3 ctrl start+region", d, 64'h1200);
      rd(8'h10, d); chk("R3 status loading", d, stat(DEPTH, 0, 1, 1));
      chk("R3 region pin", {62'b0, region_o}, 64'h2);

      // R4 credit sweep, R5 overflow
      for (int k = 1; k <= DEPTH; k++) begin
         wr(8'h18, {32'hFFFF_FFFF, 32'hA500_0000 + 32'(k * 32'h111)});
         rd(8'h10, d); chk("R4 credit after push", {55'b0, d[8:0]}, 64'(DEPTH - k));
      end
      wr(8'h18, 64'h0000_0000_0BAD_0BAD);
      rd(8'h20, d); chk("R5 overflow bit", d, 64'h10);
      rd(8'h10, d); chk("R5 credit stays zero", {55'b0, d[8:0]}, 64'h0);

      // R7 push complete and drain
      wr(8'h08, 64'h0000_0000_0000_3200);
      rd(8'h08, d); chk("R7 push bit set", {63'b0, d[13]}, 64'h1);
      rd(8'h10, d); chk("R7 ctrl status drain", {61'b0, d[22:20]}, 64'h2);
      drain_ready = 1; #1;
      idx = 0;
      for (int c = 0; c < 30 && idx < DEPTH; c++) begin
         if (drain_valid) begin got[idx] = drain_data; idx++; end
         @(negedge clk); #1;
      end
      drain_ready = 0;
      chk("R4 drained count", 64'(idx), 64'(DEPTH));
      for (int k = 1; k <= DEPTH; k++)
         chk("R4 drain order", {32'b0, got[k-1]}, {32'b0, 32'hA500_0000 + 32'(k * 32'h111)});
      idx = 0;
      rd(8'h08, d);
      while (d[12] && idx < 20) begin @(negedge clk); #1; rd(8'h08, d); idx++; end
      chk("R7 start and push cleared", {62'b0, d[13:12]}, 64'h0);
      rd(8'h10, d); chk("R7 status idle", d, stat(DEPTH, 1, 0, 0));
      wr(8'h20, 64'h10);

      // R2 flush during load
      wr(8'h08, 64'h0000_0000_0000_1100);
      wr(8'h18, 64'h1);
      wr(8'h18, 64'h2);
      rd(8'h10, d); chk("R4 credit two pushed", {55'b0, d[8:0]}, 64'(DEPTH - 2));
      do_reset_handshake("R2 flush");
      rd(8'h08, d); chk("R2 start dropped by reset", {63'b0, d[12]}, 64'h0);

      // R8 error map
      wr(8'h20, 64'h7F);
      @(negedge clk); hw_err_i = 7'h7F;
      @(negedge clk); hw_err_i = 7'h00; #1;
      rd(8'h20, d); chk("R8 all strobes, bit5 reserved", d, 64'h5F);
      rd(8'h10, d); chk("R8 status or", {63'b0, d[16]}, 64'h1);
      wr(8'h20, 64'h03);
      rd(8'h20, d); chk("R8 partial w1c", d, 64'h5C);
      wr(8'h20, 64'hFFFF_FFFF_FFFF_FF80);
      rd(8'h20, d); chk("R8 high bits no effect", d, 64'h5C);
      wr(8'h20, 64'h7F);
      rd(8'h20, d); chk("R8 all cleared", d, 64'h0);
      rd(8'h10, d); chk("R8 status or clear", {63'b0, d[16]}, 64'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule